// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer for a successive-approximation converter. A rising edge on the convert request arms a conversion. Once the request returns low, a conversion tick stream starts. The ticks come either from an internal divider of the system clock or from an externally supplied tick, and an inhibit input can hold them back. On each tick the sequencer settles one bit of a trial word, working from the most significant bit down. It reads its decision from an external comparator that compares the feedback DAC output against the analog input.

The trial word is kept in negative-true form. A 0 means the bit is set, and the same vector serves as the DAC drive and as the parallel result. A busy flag stays high from the start edge until the result is valid. The result is stable for one full system clock before busy falls, so a downstream register can capture the word on the falling edge of busy. A resolution input can end the sequence after fewer bits. An extra output gives the inverse of the top bit, which turns complementary offset binary into complementary two's complement.

Top module: `sar_seq_ctrl`

States: `ST_IDLE` (no conversion, gated tick held at 0), `ST_ARMED` (request seen, waiting for it to drop), `ST_RUN` (ticks advance the bit sequence) and `ST_SETTLE` (one cycle of data hold before busy clears). The transitions are:
- IDLE→ARMED on a request rising edge.
- ARMED→RUN once the request is low.
- RUN→SETTLE on the tick that decides the last bit.
- SETTLE→IDLE after one cycle.

## Requirements
- R1: After reset, busy_o is 0, gclk_o is 0 and trial_o is all ones.
- R2: A rising edge of start_i while idle raises busy_o on the next cycle. At that point trial_o holds 0 in its top bit (bit W-1) and 1 in every other bit.
- R3: No gated tick appears on gclk_o while start_i stays high after the edge that armed the conversion.
- R4: The first tick of a conversion decides nothing. Each later tick decides one bit, from bit W-1 down. The bit becomes 1 when cmp_hi_i is 1 (DAC above input) and 0 otherwise, and on the same tick the next lower bit is driven to 0 as its trial.
- R5: A full conversion uses exactly W+1 ticks on gclk_o. With an ideal comparator, the final trial_o is the bitwise complement of the input code.
- R6: busy_o falls exactly two system cycles after the sample of the last tick, and trial_o does not change in the cycle in which busy_o falls.
- R7: gclk_o is 0 whenever busy_o is 0.
- R8: res_bits_i is sampled at the start edge. A value N in 1..W ends the conversion after N decided bits, using N+1 ticks, and the lower W-N bits stay at 1. A value of 0 or above W gives W bits.
- R9: msb_n_o is always the inverse of trial_o[W-1].
- R10: A start_i rising edge during a conversion has no effect on the tick count or on the result.
- R11: With ext_sel_i at 1, ticks follow ext_tick_i. While inhibit_i is 1, no tick occurs and trial_o holds, and the conversion resumes correctly after release.
- R12: With ext_sel_i at 0, running ticks are spaced exactly DIV system cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Convert request; rising edge arms, low level releases ticks |
| cmp_hi_i | input | 1 | Comparator: 1 when DAC output exceeds the analog input |
| ext_sel_i | input | 1 | 1 selects the external tick, 0 the internal divider |
| ext_tick_i | input | 1 | External conversion tick, one system cycle wide |
| inhibit_i | input | 1 | Holds back conversion ticks while 1 |
| res_bits_i | input | $clog2(W+1) | Number of bits to convert (0 or above W means W) |
| busy_o | output | 1 | High from start edge until the result is valid |
| gclk_o | output | 1 | Gated conversion tick, 0 outside a conversion |
| trial_o | output | W | Negative-true trial word / parallel result |
| msb_n_o | output | 1 | Inverse of trial_o[W-1] |

## Verification
The assertions check four things on every cycle: the gated tick stays low while idle, the initial trial pattern appears as busy rises, the word holds when neither load nor decision occurs, and a single cycle always follows the settle state. They also check that inhibit suppresses ticks, that internal ticks are never adjacent, and that a running conversion cannot be re-armed. Only the bench scenarios can show that a full or short-cycled conversion converges to the complemented input code with the right tick count, and that the busy fall lags the last tick by exactly two cycles. The same holds for a mid-conversion request leaving the result untouched and for a conversion resuming correctly after an inhibit pause.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_RUN    = 2'd2,
        ST_SETTLE = 2'd3
    } sar_state_e;

endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic ext_sel_i,
    input  logic ext_tick_i,
    input  logic inhibit_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;
    logic          int_tick;

    // Divider only advances while running and not inhibited.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run_i) begin
            cnt <= '0;
        end else if (!inhibit_i) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign int_tick = (cnt == LAST);
    assign tick_o   = run_i & ~inhibit_i & (ext_sel_i ? ext_tick_i : int_tick);

    // R11: inhibit blocks every tick source
    p_inhibit_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_i |-> !tick_o);

    // R12: internal ticks are never back to back
    p_int_tick_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !ext_sel_i) |=> (ext_sel_i || !tick_o));

endmodule

// File: rtl/sar_step_fsm.sv
module sar_step_fsm
    import sar_seq_pkg::*;
#(
    parameter int W  = 12,
    parameter int RW = 4,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [RW-1:0] res_bits_i,
    input  logic          tick_i,
    output logic          busy_o,
    output logic          run_o,
    output logic          load_o,
    output logic          decide_o,
    output logic [IW-1:0] dec_idx_o,
    output logic          clr_next_o
);
    sar_state_e    state, next_state;
    logic          start_q;
    logic          start_edge;
    logic [RW-1:0] step;
    logic [RW-1:0] nbits;
    logic [RW-1:0] nbits_eff;

    assign start_edge = start_i & ~start_q;
    assign nbits_eff  = ((res_bits_i == '0) || (int'(res_bits_i) > W)) ? RW'(W) : res_bits_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= next_state;
        end
    end

    // Step counter, sampled resolution and request history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            step    <= '0;
            nbits   <= RW'(W);
        end else begin
            start_q <= start_i;
            if (load_o) begin
                step  <= '0;
                nbits <= nbits_eff;
            end else if (run_o && tick_i) begin
                step <= step + 1'b1;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        next_state = state;
        busy_o     = 1'b1;
        run_o      = 1'b0;
        load_o     = 1'b0;
        decide_o   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy_o = 1'b0;
                if (start_edge) begin
                    load_o     = 1'b1;
                    next_state = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (!start_i) next_state = ST_RUN;
            end
            ST_RUN: begin
                run_o = 1'b1;
                if (tick_i && (step != '0)) decide_o = 1'b1;
                if (tick_i && (step == nbits)) next_state = ST_SETTLE;
            end
            ST_SETTLE: begin
                next_state = ST_IDLE;
            end
        endcase
    end

    assign dec_idx_o  = IW'(W - int'(step));
    assign clr_next_o = (step != nbits);

    // R10: a running conversion never returns to the armed state
    p_no_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> (state == ST_RUN || state == ST_SETTLE));

    // R6: data hold lasts exactly one cycle
    p_settle_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE) |=> (state == ST_IDLE));

    // R8: the step count never passes the sampled resolution
    p_step_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (step <= nbits));

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int W  = 12,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          decide_i,
    input  logic [IW-1:0] idx_i,
    input  logic          clr_next_i,
    input  logic          cmp_hi_i,
    output logic [W-1:0]  q_o
);
    localparam logic [W-1:0] INIT = {1'b0, {(W-1){1'b1}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '1;
        end else if (load_i) begin
            q_o <= INIT;
        end else if (decide_i) begin
            for (int i = 0; i < W; i++) begin
                if (i == int'(idx_i)) begin
                    q_o[i] <= cmp_hi_i;
                end else if (clr_next_i && (i + 1 == int'(idx_i))) begin
                    q_o[i] <= 1'b0;
                end
            end
        end
    end

    // R4: a decision touches at most the decided bit and its successor
    p_two_bits_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
        decide_i |=> ($countones(q_o ^ $past(q_o)) <= 2));

    // R11: without load or decision the word holds
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !decide_i) |=> $stable(q_o));

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
    parameter int W   = 12,
    parameter int DIV = 4,
    localparam int RW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          cmp_hi_i,
    input  logic          ext_sel_i,
    input  logic          ext_tick_i,
    input  logic          inhibit_i,
    input  logic [RW-1:0] res_bits_i,
    output logic          busy_o,
    output logic          gclk_o,
    output logic [W-1:0]  trial_o,
    output logic          msb_n_o
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;

    logic          run;
    logic          tick;
    logic          load;
    logic          decide;
    logic [IW-1:0] dec_idx;
    logic          clr_next;

    sar_tick_gen #(.DIV(DIV)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .ext_sel_i  (ext_sel_i),
        .ext_tick_i (ext_tick_i),
        .inhibit_i  (inhibit_i),
        .tick_o     (tick)
    );

    sar_step_fsm #(.W(W), .RW(RW), .IW(IW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .res_bits_i (res_bits_i),
        .tick_i     (tick),
        .busy_o     (busy_o),
        .run_o      (run),
        .load_o     (load),
        .decide_o   (decide),
        .dec_idx_o  (dec_idx),
        .clr_next_o (clr_next)
    );

    sar_trial_reg #(.W(W), .IW(IW)) u_trial (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .decide_i   (decide),
        .idx_i      (dec_idx),
        .clr_next_i (clr_next),
        .cmp_hi_i   (cmp_hi_i),
        .q_o        (trial_o)
    );

    assign gclk_o  = tick;
    assign msb_n_o = ~trial_o[W-1];

    // R7: no gated tick outside a conversion
    p_idle_tick_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !gclk_o);

    // R2: first trial pattern is present as busy rises
    p_init_pattern_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (trial_o == {1'b0, {(W-1){1'b1}}}));

    // R6: result is already stable when busy falls
    p_data_before_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $stable(trial_o));

endmodule

// File: tb/test_sar_seq_ctrl.sv
module test_sar_seq_ctrl;
    localparam int W      = 12;
    localparam int DIV    = 4;
    localparam int CLK_NS = 10;
    localparam int NV     = 10;

    localparam logic [11:0] VIN [NV] = '{12'h000, 12'hFFF, 12'h800, 12'h7FF, 12'hA5C,
                                         12'h3D7, 12'h9B6, 12'h123, 12'h5AF, 12'hC81};
    localparam int          RES [NV] = '{12, 12, 12, 12, 12, 10, 8, 0, 15, 1};
    localparam bit          EXT [NV] = '{1, 1, 0, 1, 0, 1, 0, 1, 1, 1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          ext_sel = 1'b1;
    logic          ext_tick = 1'b1;
    logic          inhibit = 1'b0;
    logic [3:0]    res_bits = 4'd12;
    logic [11:0]   vin = '0;
    logic          busy, gclk, msb_n, cmp_hi;
    logic [11:0]   trial;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_NS/2) clk = ~clk;

    // behavioural comparator: DAC value is the complement of the trial word
    assign cmp_hi = ((~trial) > vin);

    sar_seq_ctrl #(.W(W), .DIV(DIV)) i_sar_seq_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .cmp_hi_i   (cmp_hi),
        .ext_sel_i  (ext_sel),
        .ext_tick_i (ext_tick),
        .inhibit_i  (inhibit),
        .res_bits_i (res_bits),
        .busy_o     (busy),
        .gclk_o     (gclk),
        .trial_o    (trial),
        .msb_n_o    (msb_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic convert(input logic [11:0] v, input int n, input bit ext,
                           input int poke, input int inh);
        int          neff;
        logic [11:0] mask, expv, hold, frozen;
        int          ticks, cyc, last, gap_bad, stall_ticks;
        bit          stall_move;
        neff = (n == 0 || n > W) ? W : n;
        mask = ~(12'hFFF >> neff);
        expv = ~(v & mask);
        vin = v; res_bits = 4'(n); ext_sel = ext;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R2 busy after start edge", int'(busy), 1);
        chk(trial == 12'h7FF, "R2 initial pattern", int'(trial), 12'h7FF);
        @(negedge clk);
        chk(gclk == 1'b0, "R3 no tick while start high", int'(gclk), 0);
        start = 1'b0;
        ticks = 0; cyc = 0; last = 0; gap_bad = 0; hold = trial;
        stall_ticks = 0; stall_move = 0;
        while (busy && cyc < 5000) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (busy) hold = trial;
            if (gclk) begin
                if (ticks > 0 && !ext && inh == 0 && (cyc - last) != DIV) gap_bad++;
                ticks++;
                last = cyc;
                if (ticks == poke) start = 1'b1;
                if (ticks == inh) begin
                    inhibit = 1'b1;
                    @(negedge clk);
                    cyc++;
                    frozen = trial;
                    for (int k = 0; k < 8; k++) begin
                        @(negedge clk);
                        cyc++;
                        if (gclk) stall_ticks++;
                        if (trial != frozen || !busy) stall_move = 1;
                    end
                    inhibit = 1'b0;
                end
            end
        end
        chk(cyc < 5000, "R5 conversion completes", cyc, 0);
        chk(ticks == neff + 1, "R5/R8 tick count", ticks, neff + 1);
        chk(trial == expv, "R4/R5/R8 result word", int'(trial), int'(expv));
        chk(msb_n == ~trial[11], "R9 inverted top bit", int'(msb_n), int'(~trial[11]));
        chk(trial == hold, "R6 data stable at busy fall", int'(trial), int'(hold));
        chk(cyc - last == 2, "R6 busy fall delay", cyc - last, 2);
        if (!ext && inh == 0) chk(gap_bad == 0, "R12 internal tick spacing", gap_bad, 0);
        if (inh != 0) begin
            chk(stall_ticks == 0, "R11 no tick while inhibited", stall_ticks, 0);
            chk(!stall_move, "R11 word holds while inhibited", int'(stall_move), 0);
        end
        repeat (3) @(negedge clk);
        chk(gclk == 1'b0 && busy == 1'b0, "R7 idle tick low", int'(gclk), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        chk(gclk == 1'b0, "R1 reset tick", int'(gclk), 0);
        chk(trial == 12'hFFF, "R1 reset word", int'(trial), 12'hFFF);
        chk(msb_n == 1'b0, "R9 reset inverted top bit", int'(msb_n), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            convert(VIN[i], RES[i], EXT[i], 0, 0);
        end

        // R10: request edge in the middle of a conversion
        convert(12'h6A3, 12, 1'b1, 5, 0);
        convert(12'hD12, 10, 1'b0, 4, 0);
        // R11: inhibit pause in both tick modes
        convert(12'h2C4, 12, 1'b0, 0, 6);
        convert(12'hE39, 12, 1'b1, 0, 3);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule